// File: doc/BRIEF.md
# Indirectly Addressed Event and Cycle Counter Bank

This block holds a configurable number of 32-bit event counters and one 64-bit cycle counter. Software reaches every register through a two-step indirect path: a write to the select port latches a 12-bit register address, and a later data write or a data read acts on the register at that address. Each event counter counts single-cycle pulses from an outside source. The cycle counter counts every clock. A counter advances only while the global run bit and its own enable bit are both set.

Three 32-bit masks govern the counters: counter enable, interrupt enable and overflow status. Each mask has one address that sets bits on writing ones and another that clears bits on writing ones. Event counter n owns mask bit n. The cycle counter always owns bit 31, however many event counters are built. When a counter rolls over from all ones to zero, its status bit becomes set and stays set. The single interrupt line is high while any status bit is set whose interrupt-enable bit is also set.

Top module: `pmu_bank`

## Requirements
- R1: After reset, every counter reads 0, all three masks read 0, the run bit is 0 and `irq` is low.
- R2: A read of the control register (0x400) returns the run bit in bit 0 and the number of event counters in bits 15:11. All other bits read 0.
- R3: A control write with bit 1 set zeroes every event counter, and one with bit 2 set zeroes the cycle counter, so writing 0x6 zeroes them all. Bits 1 and 2 are not stored. Bit 0 of the same write sets the run bit. Overflow status is not touched.
- R4: Writing ones to 0x404 sets counter-enable bits and writing ones to 0x403 clears them. For interrupt enable, 0x406 sets and 0x405 clears. Both addresses of a pair read back the mask. Only bits 0..N-1 and bit 31 exist, and all other bits read 0.
- R5: Event counter n (value at 0x421 + 0x10·n) advances by one at each clock edge where its pulse input is high, the run bit is 1 and enable bit n is 1. Otherwise it holds its value.
- R6: The cycle counter (value at 0x40A, 64 bits) advances by one at every clock edge where the run bit and enable bit 31 are both 1.
- R7: A data write to a counter's address loads that counter. An event counter takes the low 32 bits. An increment due in the same cycle is dropped, so the written value is what the counter holds.
- R8: When a counter rolls over from all ones to zero, its status bit is set at the same clock edge. A status bit clears only on a write of one to 0x407. A write of one to 0x408 sets a status bit, and both addresses read the status. A rollover wins over a clear in the same cycle.
- R9: `irq` is high exactly while the bitwise AND of the overflow status and the interrupt enable is non-zero.
- R10: Reads of unmapped addresses return 0, and data writes to them change no register.
- R11: The cycle counter carries from bit 31 into bit 32 without setting any overflow status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Latch `sel_addr` into the select register |
| sel_addr | input | 12 | Register address to select |
| dat_wr | input | 1 | Write `dat_wdata` to the selected register |
| dat_wdata | input | 64 | Write data |
| dat_rdata | output | 64 | Contents of the selected register, zero-extended |
| evt_pulse | input | NUM_EVT | One increment pulse per event counter |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a rollover that lands in the same cycle as a software write-one-to-clear of the same status bit. The status write is issued through the select/data pair. The bench preloads an event counter with all ones and raises that counter's pulse during exactly the cycle in which the clear is written, so the status must still read set afterwards. The same approach of lining up a pulse with the data-write cycle covers the dropped increment on a load. For the 64-bit counter, preloading values just below the 32-bit and 64-bit boundaries exposes both the carry into the upper word and the full rollover within a few cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W  = 12;
  localparam int MASK_W  = 32;
  localparam int CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h400;
  localparam logic [ADDR_W-1:0] A_CEN_CLR = 12'h403;
  localparam logic [ADDR_W-1:0] A_CEN_SET = 12'h404;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 12'h405;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 12'h406;
  localparam logic [ADDR_W-1:0] A_OVF_CLR = 12'h407;
  localparam logic [ADDR_W-1:0] A_OVF_SET = 12'h408;
  localparam logic [ADDR_W-1:0] A_CYC     = 12'h40A;
  localparam int EVT_BASE   = 'h421;
  localparam int EVT_STRIDE = 'h10;

  // address of event counter n
  function automatic logic [ADDR_W-1:0] evt_addr(int n);
    return ADDR_W'(EVT_BASE + n * EVT_STRIDE);
  endfunction

  // bits that exist in every mask: events 0..nevt-1 plus the cycle bit
  function automatic logic [MASK_W-1:0] valid_mask(int nevt);
    logic [MASK_W-1:0] m;
    m = (MASK_W'(1) << nevt) - MASK_W'(1);
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

  // control register readback image
  function automatic logic [MASK_W-1:0] ctrl_image(logic run, int nevt);
    logic [MASK_W-1:0] r;
    r = '0;
    r[0] = run;
    r[15:11] = 5'(nevt);
    return r;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic step;
  // load and clear take priority; a coinciding increment is lost
  assign step = inc & ~ld & ~clr;
  assign wrap = step & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (step) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pmu_mask.sv
module pmu_mask #(
  parameter int                 W     = 32,
  parameter logic [W-1:0]       VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;
  always_comb begin
    nxt = q & ~(clr_wr ? wdata : '0);
    nxt = nxt | (set_wr ? wdata : '0) | hw_set;
    nxt = nxt & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 32,
  parameter int CYC_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic              dat_wr,
  input  logic [CYC_W-1:0]  dat_wdata,
  output logic [CYC_W-1:0]  dat_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic              irq
);
  localparam logic [MASK_W-1:0] VMASK = valid_mask(NUM_EVT);

  logic [ADDR_W-1:0]        sel_q;
  logic                     glb_en_q;
  logic [MASK_W-1:0]        cnten_q, inten_q, ovs_q, wrap_vec;
  logic [NUM_EVT-1:0]       evt_wrap;
  logic                     cyc_wrap;
  logic [EVT_W-1:0]         evt_cnt [NUM_EVT];
  logic [NUM_EVT*EVT_W-1:0] evt_flat;
  logic [CYC_W-1:0]         cyc_cnt;
  logic                     wr_ctrl, clr_evt, clr_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_addr;
  end

  assign wr_ctrl = dat_wr && (sel_q == A_CTRL);
  assign clr_evt = wr_ctrl && dat_wdata[1];
  assign clr_cyc = wr_ctrl && dat_wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n)       glb_en_q <= 1'b0;
    else if (wr_ctrl) glb_en_q <= dat_wdata[0];
  end

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
    logic ld;
    assign ld = dat_wr && (sel_q == evt_addr(n));
    pmu_counter #(.W(EVT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .ld(ld),
      .ld_val(dat_wdata[EVT_W-1:0]),
      .inc(glb_en_q & cnten_q[n] & evt_pulse[n]),
      .cnt(evt_cnt[n]), .wrap(evt_wrap[n])
    );
    assign evt_flat[n*EVT_W +: EVT_W] = evt_cnt[n];
  end

  pmu_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(clr_cyc),
    .ld(dat_wr && (sel_q == A_CYC)), .ld_val(dat_wdata),
    .inc(glb_en_q & cnten_q[CYC_BIT]),
    .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_EVT-1:0] = evt_wrap;
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  pmu_mask #(.W(MASK_W), .VALID(VMASK)) u_cnten (
    .clk(clk), .rst_n(rst_n),
    .set_wr(dat_wr && (sel_q == A_CEN_SET)), .clr_wr(dat_wr && (sel_q == A_CEN_CLR)),
    .wdata(dat_wdata[MASK_W-1:0]), .hw_set('0), .q(cnten_q)
  );

  pmu_mask #(.W(MASK_W), .VALID(VMASK)) u_inten (
    .clk(clk), .rst_n(rst_n),
    .set_wr(dat_wr && (sel_q == A_IEN_SET)), .clr_wr(dat_wr && (sel_q == A_IEN_CLR)),
    .wdata(dat_wdata[MASK_W-1:0]), .hw_set('0), .q(inten_q)
  );

  pmu_mask #(.W(MASK_W), .VALID(VMASK)) u_ovs (
    .clk(clk), .rst_n(rst_n),
    .set_wr(dat_wr && (sel_q == A_OVF_SET)), .clr_wr(dat_wr && (sel_q == A_OVF_CLR)),
    .wdata(dat_wdata[MASK_W-1:0]), .hw_set(wrap_vec), .q(ovs_q)
  );

  assign irq = |(ovs_q & inten_q);

  always_comb begin
    dat_rdata = '0;
    case (sel_q)
      A_CTRL:               dat_rdata = CYC_W'(ctrl_image(glb_en_q, NUM_EVT));
      A_CEN_CLR, A_CEN_SET: dat_rdata = CYC_W'(cnten_q);
      A_IEN_CLR, A_IEN_SET: dat_rdata = CYC_W'(inten_q);
      A_OVF_CLR, A_OVF_SET: dat_rdata = CYC_W'(ovs_q);
      A_CYC:                dat_rdata = cyc_cnt;
      default: begin
        for (int n = 0; n < NUM_EVT; n++)
          if (sel_q == evt_addr(n)) dat_rdata = CYC_W'(evt_cnt[n]);
      end
    endcase
  end
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 32,
  parameter int CYC_W   = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dat_wr,
  input logic [ADDR_W-1:0]        sel_q,
  input logic [1:0]               rst_bits,
  input logic                     glb_en,
  input logic [MASK_W-1:0]        cnten_q,
  input logic [MASK_W-1:0]        inten_q,
  input logic [MASK_W-1:0]        ovs_q,
  input logic [MASK_W-1:0]        wrap_vec,
  input logic [CYC_W-1:0]         cyc_cnt,
  input logic [NUM_EVT*EVT_W-1:0] evt_flat,
  input logic                     irq
);
  p_reset_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && sel_q == A_CTRL && rst_bits == 2'b11) |=> (cyc_cnt == '0 && evt_flat == '0));

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !dat_wr) |=> ($stable(cyc_cnt) && $stable(evt_flat)));

  p_cyc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && cnten_q[CYC_BIT] && !dat_wr) |=> (cyc_cnt == $past(cyc_cnt) + CYC_W'(1)));

  p_wrap_sets_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovs_q & $past(wrap_vec)) == $past(wrap_vec)));

  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && sel_q == A_OVF_CLR) |=> ((ovs_q & $past(ovs_q)) == $past(ovs_q)));

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ovs_q != $past(ovs_q) || inten_q != $past(inten_q)));
endmodule

bind pmu_bank pmu_bank_chk #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .sel_q(sel_q),
  .rst_bits(dat_wdata[2:1]), .glb_en(glb_en_q), .cnten_q(cnten_q),
  .inten_q(inten_q), .ovs_q(ovs_q), .wrap_vec(wrap_vec),
  .cyc_cnt(cyc_cnt), .evt_flat(evt_flat), .irq(irq)
);

// File: tb/pmu_bank_bench.sv
`timescale 1ns/1ps
module pmu_bank_bench;
  import pmu_pkg::*;
  localparam int NE = 8;

  logic clk = 1'b0, rst_n = 1'b0, sel_wr = 1'b0, dat_wr = 1'b0;
  logic [ADDR_W-1:0] sel_addr = '0;
  logic [63:0] dat_wdata = '0;
  logic [63:0] dat_rdata;
  logic [NE-1:0] evt_pulse = '0;
  logic irq;

  always #4 clk = ~clk;

  pmu_bank #(.NUM_EVT(NE), .EVT_W(32), .CYC_W(64)) u_pmu_bank (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_addr(sel_addr),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  typedef struct { bit is_irq; logic [63:0] exp; string tag; } item_t;
  item_t sbq[$];
  logic mon_req = 1'b0;
  int total = 0, bad = 0;
  bit finished = 0;

  // monitor: compares scoreboard items away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [63:0] act;
    if (mon_req && sbq.size() > 0) begin
      it = sbq.pop_front();
      act = it.is_irq ? {63'd0, irq} : dat_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic set_sel(logic [ADDR_W-1:0] a);
    sel_wr = 1'b1; sel_addr = a; tick(); sel_wr = 1'b0;
  endtask
  task automatic wr(logic [ADDR_W-1:0] a, logic [63:0] d, logic [NE-1:0] pm = '0);
    set_sel(a);
    dat_wr = 1'b1; dat_wdata = d; evt_pulse = pm;
    tick();
    dat_wr = 1'b0; evt_pulse = '0;
  endtask
  task automatic expect_rd(logic [ADDR_W-1:0] a, logic [63:0] e, string tag);
    set_sel(a);
    sbq.push_back('{1'b0, e, tag});
    mon_req = 1'b1; tick(); mon_req = 1'b0;
  endtask
  task automatic expect_irq(logic e, string tag);
    sbq.push_back('{1'b1, {63'd0, e}, tag});
    mon_req = 1'b1; tick(); mon_req = 1'b0;
  endtask
  task automatic pulses(logic [NE-1:0] m, int n);
    for (int k = 0; k < n; k++) begin evt_pulse = m; tick(); end
    evt_pulse = '0;
  endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    expect_rd(A_CYC, 64'd0, "R1 cycle counter");
    expect_rd(evt_addr(0), 64'd0, "R1 event counter 0");
    expect_rd(A_OVF_SET, 64'd0, "R1 overflow status");
    expect_rd(A_CEN_SET, 64'd0, "R1 counter enable");
    expect_irq(1'b0, "R1 irq low");
    // R2 control readback: count 8 in bits 15:11
    expect_rd(A_CTRL, 64'h4000, "R2 control image");

    // R10 unmapped address
    wr(12'h401, 64'hFFFF_FFFF);
    expect_rd(12'h401, 64'd0, "R10 unmapped read");
    expect_rd(A_CTRL, 64'h4000, "R10 control untouched");
    expect_rd(A_IEN_SET, 64'd0, "R10 int enable untouched");

    // R4 set/clear masks
    wr(A_CEN_SET, 64'hFFFF_FFFF);
    expect_rd(A_CEN_SET, 64'h8000_00FF, "R4 enable set, only valid bits");
    wr(A_CEN_CLR, 64'h8000_000F);
    expect_rd(A_CEN_CLR, 64'h0000_00F0, "R4 enable clear");
    wr(A_IEN_SET, 64'h3000_0010);
    expect_rd(A_IEN_CLR, 64'h0000_0010, "R4 int enable set");
    wr(A_IEN_CLR, 64'h0000_0010);
    expect_rd(A_IEN_SET, 64'd0, "R4 int enable clear");

    // R5 gating
    pulses(8'h30, 3);
    expect_rd(evt_addr(4), 64'd0, "R5 global run off");
    wr(A_CTRL, 64'h1);
    pulses(8'h14, 3);
    expect_rd(evt_addr(2), 64'd0, "R5 counter disabled");
    expect_rd(evt_addr(4), 64'd3, "R5 counts pulses");

    // R7 load drops coinciding increment
    wr(A_CEN_SET, 64'h2);
    wr(evt_addr(1), 64'hABCD_0000_0000_0005, 8'h02);
    expect_rd(evt_addr(1), 64'd5, "R7 load wins over pulse");
    pulses(8'h02, 1);
    expect_rd(evt_addr(1), 64'd6, "R7 counts after load");

    // R8/R9 event rollover
    wr(evt_addr(0), 64'hFFFF_FFFE);
    wr(A_CEN_SET, 64'h1);
    wr(A_IEN_SET, 64'h1);
    pulses(8'h01, 2);
    idle(4);
    expect_rd(evt_addr(0), 64'd0, "R8 event rolled to zero");
    expect_rd(A_OVF_SET, 64'h1, "R8 status set and sticky");
    expect_irq(1'b1, "R9 irq on enabled status");
    wr(A_OVF_CLR, 64'h1);
    expect_rd(A_OVF_CLR, 64'd0, "R8 write-one clear");
    expect_irq(1'b0, "R9 irq drops after clear");

    // R8 rollover beats a same-cycle clear
    wr(evt_addr(3), 64'hFFFF_FFFF);
    wr(A_CEN_SET, 64'h8);
    wr(A_OVF_CLR, 64'h8, 8'h08);
    expect_rd(A_OVF_SET, 64'h8, "R8 set beats clear");
    expect_irq(1'b0, "R9 status masked");
    wr(A_IEN_SET, 64'h8);
    expect_irq(1'b1, "R9 irq after enable");
    wr(A_OVF_SET, 64'h8000_0100);
    expect_rd(A_OVF_SET, 64'h8000_0008, "R8 software set");
    wr(A_OVF_CLR, 64'hFFFF_FFFF);
    wr(A_IEN_CLR, 64'hFFFF_FFFF);
    expect_irq(1'b0, "R9 all cleared");

    // R6 cycle counter: 1 + 10 idle + 1 edges while running
    wr(A_CTRL, 64'h0);
    wr(A_CEN_SET, 64'h8000_0000);
    wr(A_CTRL, 64'h1);
    idle(10);
    wr(A_CTRL, 64'h0);
    expect_rd(A_CYC, 64'd12, "R6 cycle count");

    // R11 carry into upper word
    wr(A_CYC, 64'h0000_0000_FFFF_FFFF);
    wr(A_CTRL, 64'h1);
    wr(A_CTRL, 64'h0);
    expect_rd(A_CYC, 64'h0000_0001_0000_0001, "R11 carry into bit 32");
    expect_rd(A_OVF_SET, 64'd0, "R11 no status at bit 32");

    // R8 cycle counter full rollover uses bit 31
    wr(A_CYC, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_CTRL, 64'h1);
    wr(A_CTRL, 64'h0);
    expect_rd(A_CYC, 64'd1, "R8 cycle rolled over");
    expect_rd(A_OVF_SET, 64'h8000_0000, "R8 cycle status bit 31");
    wr(A_IEN_SET, 64'h8000_0000);
    expect_irq(1'b1, "R9 cycle irq");

    // R7 load of running cycle counter
    wr(A_CTRL, 64'h1);
    wr(A_CYC, 64'd100);
    wr(A_CTRL, 64'h0);
    expect_rd(A_CYC, 64'd102, "R7 cycle load wins");

    // R3 counter resets
    wr(A_CTRL, 64'h6);
    expect_rd(evt_addr(4), 64'd0, "R3 event 4 zeroed");
    expect_rd(evt_addr(1), 64'd0, "R3 event 1 zeroed");
    expect_rd(A_CYC, 64'd0, "R3 cycle zeroed");
    expect_rd(A_CTRL, 64'h4000, "R3 reset bits not stored");
    expect_rd(A_OVF_SET, 64'h8000_0000, "R3 status kept");
    wr(evt_addr(0), 64'd9);
    wr(A_CYC, 64'd9);
    wr(A_CTRL, 64'h2);
    expect_rd(evt_addr(0), 64'd0, "R3 bit1 zeroes events");
    expect_rd(A_CYC, 64'd9, "R3 bit1 keeps cycle");

    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule